// File: doc/BRIEF.md
# Flash CFI Query Mode Controller

This block is the command side of a parallel NOR flash read path. It watches host write cycles and keeps track of the read mode the part is in: plain array read, autoselect (identifier) read, or CFI query. On a host read it returns one of three things. In array mode it returns a word from a small internal stub memory. In autoselect mode it returns an identifier word. In query mode it returns a word from a fixed CFI query table.

The query mode remembers which mode it was entered from. A reset command written while in query mode goes back to that mode, so a host that enters the query from autoselect finds itself back in autoselect afterwards. Commands are decoded from the low byte of the write data only. Program and erase algorithms, operation timing and the full unlock sequence are outside this block. Autoselect entry is a single command write.

Top module: `flash_cfi_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in array mode and holds rd_valid low while reset is asserted.
- R2: A read strobe sampled on a clock edge gives rd_valid high and the read word on rd_data from that edge until the next one. In array mode the word at address A (8-bit) is {A, A} XOR 16'hA55A.
- R3: A write with low data byte 98h to address 55h, made while ready is high and the block is in array mode, enters query mode.
- R4: A query command written while ready is low, or 98h written to any address other than 55h, leaves the mode unchanged.
- R5: A write of 90h to address 55h in array mode enters autoselect mode. In autoselect mode, address 00h reads 00A5h, address 01h reads 5A3Ch, and every other address reads 0000h. A write of F0h to any address in autoselect mode returns to array mode.
- R6: A write of 98h to address 55h while ready is high and the block is in autoselect mode enters query mode.
- R7: A write with low data byte F0h to any address in query mode leaves query mode. The block returns to autoselect if query mode was entered from autoselect, and to array mode otherwise. The upper data byte is ignored.
- R8: In query mode, addresses 10h, 11h and 12h read 0051h, 0052h and 0059h. Address 13h reads 0002h, 15h reads 0040h, and 14h, 16h and 17h–1Ah read 0000h.
- R9: In query mode, the supply-voltage words are 0027h at 1Bh and 0036h at 1Ch. The programming-voltage words at 1Dh and 1Eh read 0000h.
- R10: In query mode, addresses 1Fh through 26h read 0004h, 0000h, 000Ah, 0000h, 0005h, 0000h, 0004h, 0000h, in that order.
- R11: In query mode, every address below 10h or above 26h reads 0000h.
- R12: A write whose low data byte is none of the recognised commands leaves the mode unchanged. In query mode this includes 90h and 98h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready | input | 1 | Device ready; query entry is refused while low |
| addr | input | 8 | Word address shared by reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per command |
| wr_data | input | 16 | Write data; only the low byte is decoded |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read word, valid the cycle after rd_en |
| rd_valid | output | 1 | High the cycle after a read strobe |

## Verification
The read path is tried with the same address set, 10h among them, in each of the three modes. Because the array word, the identifier word and the query word differ at those addresses, each read shows which mode is active. Command writes are applied with ready both high and low, at the command address and at a neighbouring one, and with stray data bytes and a set upper byte. These patterns separate a correct decode from one that checks too few bits or ignores ready. Query entry is made from both array mode and autoselect, followed by a reset command. This tells a design that remembers the origin mode from one that always falls back to array mode.

// File: rtl/flash_cfi_pkg.sv
package flash_cfi_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_QUERY   = 2'd2
  } cfi_mode_e;

  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_AUTOSEL = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_ADDR    = 8'h55;

endpackage

// File: rtl/cfi_mode_fsm.sv
module cfi_mode_fsm
  import flash_cfi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  output cfi_mode_e         mode,
  output logic              from_auto
);

  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(CMD_ADDR);

  cfi_mode_e mode_n;
  logic      from_auto_n;
  logic      at_key;

  assign at_key = (addr == KEY_ADDR);

  always_comb begin
    mode_n      = mode;
    from_auto_n = from_auto;
    if (wr_en) begin
      unique case (mode)
        MODE_ARRAY: begin
          if (cmd == CMD_QUERY && at_key && ready) begin
            mode_n      = MODE_QUERY;
            from_auto_n = 1'b0;
          end else if (cmd == CMD_AUTOSEL && at_key) begin
            mode_n = MODE_AUTOSEL;
          end
        end
        MODE_AUTOSEL: begin
          if (cmd == CMD_QUERY && at_key && ready) begin
            mode_n      = MODE_QUERY;
            from_auto_n = 1'b1;
          end else if (cmd == CMD_RESET) begin
            mode_n = MODE_ARRAY;
          end
        end
        MODE_QUERY: begin
          if (cmd == CMD_RESET) begin
            mode_n = from_auto ? MODE_AUTOSEL : MODE_ARRAY;
          end
        end
        default: mode_n = MODE_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_ARRAY;
      from_auto <= 1'b0;
    end else begin
      mode      <= mode_n;
      from_auto <= from_auto_n;
    end
  end

endmodule

// File: rtl/cfi_query_rom.sv
module cfi_query_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);

  function automatic logic [DATA_W-1:0] entry(input logic [ADDR_W-1:0] a);
    logic [15:0] w;
    case (a)
      ADDR_W'(8'h10): w = 16'h0051;
      ADDR_W'(8'h11): w = 16'h0052;
      ADDR_W'(8'h12): w = 16'h0059;
      ADDR_W'(8'h13): w = 16'h0002;
      ADDR_W'(8'h15): w = 16'h0040;
      ADDR_W'(8'h1B): w = 16'h0027;
      ADDR_W'(8'h1C): w = 16'h0036;
      ADDR_W'(8'h1F): w = 16'h0004;
      ADDR_W'(8'h21): w = 16'h000A;
      ADDR_W'(8'h23): w = 16'h0005;
      ADDR_W'(8'h25): w = 16'h0004;
      default:        w = 16'h0000;
    endcase
    return DATA_W'(w);
  endfunction

  always_ff @(posedge clk) begin
    if (rd_en) q <= entry(addr);
  end

endmodule

// File: rtl/cfi_array_stub.sv
module cfi_array_stub #(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 16,
  parameter logic [15:0] SEED   = 16'hA55A
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(SEED) ^ ((DATA_W'(i) << ADDR_W) | DATA_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end

endmodule

// File: rtl/flash_cfi_ctrl.sv
module flash_cfi_ctrl
  import flash_cfi_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 16,
  parameter logic [15:0] MFR_ID  = 16'h00A5,
  parameter logic [15:0] DEV_ID  = 16'h5A3C,
  parameter logic [15:0] SEED    = 16'hA55A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  cfi_mode_e         cur_mode;
  logic              from_auto;
  cfi_mode_e         sel_q;
  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] qry_q;
  logic [DATA_W-1:0] id_q;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:8];

  cfi_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .wr_en     (wr_en),
    .addr      (addr),
    .cmd       (wr_data[7:0]),
    .mode      (cur_mode),
    .from_auto (from_auto)
  );

  cfi_array_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) u_arr (
    .clk   (clk),
    .rd_en (rd_en),
    .addr  (addr),
    .q     (arr_q)
  );

  cfi_query_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qry (
    .clk   (clk),
    .rd_en (rd_en),
    .addr  (addr),
    .q     (qry_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q     <= '0;
      sel_q    <= MODE_ARRAY;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        sel_q <= cur_mode;
        if (addr == '0)                 id_q <= DATA_W'(MFR_ID);
        else if (addr == ADDR_W'(1))    id_q <= DATA_W'(DEV_ID);
        else                            id_q <= '0;
      end
    end
  end

  always_comb begin
    unique case (sel_q)
      MODE_AUTOSEL: rd_data = id_q;
      MODE_QUERY:   rd_data = qry_q;
      default:      rd_data = arr_q;
    endcase
  end

endmodule

// File: rtl/flash_cfi_chk.sv
module flash_cfi_chk
  import flash_cfi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        cmd,
  input logic              rd_en,
  input logic              rd_valid,
  input cfi_mode_e         mode,
  input logic              from_auto
);

  logic key;
  assign key = (addr == ADDR_W'(CMD_ADDR));

  // R1
  reset_array_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode == MODE_ARRAY && !rd_valid));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R3
  query_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ARRAY && wr_en && key && cmd == CMD_QUERY && ready)
      |=> (mode == MODE_QUERY && !from_auto));

  // R4
  not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_QUERY && wr_en && cmd == CMD_QUERY && !ready)
      |=> $stable(mode));

  // R6
  query_from_auto_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_AUTOSEL && wr_en && key && cmd == CMD_QUERY && ready)
      |=> (mode == MODE_QUERY && from_auto));

  // R7
  query_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_QUERY && wr_en && cmd == CMD_RESET)
      |=> (mode == ($past(from_auto) ? MODE_AUTOSEL : MODE_ARRAY)));

  // R12
  query_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_QUERY && !(wr_en && cmd == CMD_RESET))
      |=> mode == MODE_QUERY);

endmodule

bind flash_cfi_ctrl flash_cfi_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .addr      (addr),
  .wr_en     (wr_en),
  .cmd       (wr_data[7:0]),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .mode      (cur_mode),
  .from_auto (from_auto)
);

// File: tb/flash_cfi_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cfi_ctrl_tb;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ready = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  item_t sb[$];

  always #2 clk = ~clk;

  flash_cfi_ctrl u_dut (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  function automatic logic [15:0] arr_word(input logic [7:0] a);
    return {a, a} ^ 16'hA55A;
  endfunction

  function automatic logic [15:0] qry_word(input logic [7:0] a);
    case (a)
      8'h10: return 16'h0051;
      8'h11: return 16'h0052;
      8'h12: return 16'h0059;
      8'h13: return 16'h0002;
      8'h15: return 16'h0040;
      8'h1B: return 16'h0027;
      8'h1C: return 16'h0036;
      8'h1F: return 16'h0004;
      8'h21: return 16'h000A;
      8'h23: return 16'h0005;
      8'h25: return 16'h0004;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] id_word(input logic [7:0] a);
    if (a == 8'h00) return 16'h00A5;
    if (a == 8'h01) return 16'h5A3C;
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input logic rdy);
    @(posedge clk); #1;
    addr = a; wr_data = d; ready = rdy; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; ready = 1'b1;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [15:0] exp, input string req);
    item_t it;
    @(posedge clk); #1;
    it.exp = exp; it.req = req;
    sb.push_back(it);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // monitor: pops one expected item per valid read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb.size() == 0) begin
        check("R2 unexpected valid", 16'h0001, 16'h0000);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.req, rd_data, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: valid stays low during reset even with a read strobe
    rd_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rd_valid in reset", {15'd0, rd_valid}, 16'h0000);
    #1 rd_en = 1'b0;
    @(posedge clk); #1 rst = 1'b0;

    // R1/R2: array mode after reset
    do_read(8'h10, arr_word(8'h10), "R1 array after reset");
    do_read(8'h00, arr_word(8'h00), "R2 array 00");
    do_read(8'h55, arr_word(8'h55), "R2 array 55");
    do_read(8'hFF, arr_word(8'hFF), "R2 array FF");

    // R4: refused query commands
    do_write(8'h55, 16'h0098, 1'b0);
    do_read(8'h10, arr_word(8'h10), "R4 not ready");
    do_write(8'h54, 16'h0098, 1'b1);
    do_read(8'h10, arr_word(8'h10), "R4 wrong address");

    // R12: stray data in array mode
    do_write(8'h56, 16'h0090, 1'b1);
    do_read(8'h01, arr_word(8'h01), "R12 autosel wrong addr");

    // R3: query entry from array
    do_write(8'h55, 16'h0098, 1'b1);
    for (int a = 8'h10; a <= 8'h1C; a++) begin
      do_read(8'(a), qry_word(8'(a)), (a <= 8'h1A) ? "R3 R8 query id" : "R9 voltage");
    end
    for (int a = 8'h1D; a <= 8'h1E; a++) do_read(8'(a), 16'h0000, "R9 no vpp");
    for (int a = 8'h1F; a <= 8'h26; a++) do_read(8'(a), qry_word(8'(a)), "R10 timeouts");
    do_read(8'h00, 16'h0000, "R11 low");
    do_read(8'h0F, 16'h0000, "R11 0F");
    do_read(8'h27, 16'h0000, "R11 27");
    do_read(8'hFF, 16'h0000, "R11 FF");

    // R12: non-reset writes keep query mode
    do_write(8'h55, 16'h0090, 1'b1);
    do_read(8'h10, 16'h0051, "R12 90 in query");
    do_write(8'h55, 16'h0098, 1'b1);
    do_read(8'h11, 16'h0052, "R12 98 in query");
    do_write(8'h23, 16'h0000, 1'b1);
    do_read(8'h12, 16'h0059, "R12 00 in query");

    // R7: exit back to array, upper byte ignored
    do_write(8'h23, 16'h3CF0, 1'b1);
    do_read(8'h10, arr_word(8'h10), "R7 back to array");

    // R5: autoselect
    do_write(8'h55, 16'h0090, 1'b1);
    do_read(8'h00, id_word(8'h00), "R5 id 00");
    do_read(8'h01, id_word(8'h01), "R5 id 01");
    do_read(8'h10, 16'h0000, "R5 id other");

    // R4 in autoselect
    do_write(8'h55, 16'h0098, 1'b0);
    do_read(8'h00, id_word(8'h00), "R4 not ready autosel");

    // R6: query entry from autoselect
    do_write(8'h55, 16'h0098, 1'b1);
    do_read(8'h11, 16'h0052, "R6 query from autosel");

    // R7: exit back to autoselect
    do_write(8'h80, 16'h00F0, 1'b1);
    do_read(8'h01, id_word(8'h01), "R7 back to autosel");

    // R5: reset from autoselect to array
    do_write(8'h00, 16'h00F0, 1'b1);
    do_read(8'h10, arr_word(8'h10), "R5 autosel exit");

    repeat (4) @(posedge clk);
    n_vec++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2: got %0d pending reads expected 0", sb.size());
    end
    finish_run();
  end

endmodule